// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sequences successive-approximation conversions for an analog front end that it does not contain. It divides the system clock into a conversion clock. It counts conversion cycles at half-cycle resolution, so the sample-and-hold strobe can land halfway through a conversion-clock period. When a conversion completes, it latches the converter's 10-bit output and raises a completion flag.

Three operating styles are supported. In single mode, a software start request runs one conversion. In free-running mode, conversions follow each other back to back. In triggered mode, a rising edge on an external trigger line starts a conversion with a fixed latency. The first conversion after the block is enabled runs longer than later ones, which gives the analog circuitry time to settle. Dropping the enable stops everything and makes the next conversion a long one again.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The conversion clock period is 2^(psel+1) system cycles for psel 0..6, and psel 7 also selects 128. While `en` is low, the divider is held at its start point.
- R2: A `start_set` pulse while enabled, idle and not in triggered mode raises `start_bit`. The conversion then begins on the next rising conversion-clock edge. A `start_set` while `en` is low leaves `start_bit` low.
- R3: A conversion lasts 13 conversion-clock cycles. The first conversion after `en` rises lasts 25 cycles.
- R4: `sample_strobe` pulses for one system cycle, 1.5 conversion-clock cycles after a normal conversion starts and 13.5 cycles after a first conversion starts. In every conversion the strobe leads completion by 11.5 conversion-clock cycles.
- R5: On completion, `result` takes `data_in` and `done_flag` rises. In single and triggered modes, `start_bit` falls in that same cycle.
- R6: In triggered mode (`mode`=2), a rising `trig_in` seen while idle is synchronised over 3 system cycles. It then restarts the divider, so a normal strobe appears 2 conversion-clock cycles later. A trigger rising edge counted from the edge before which `trig_in` rose therefore gives the strobe at edge 3+4·h, where h is half the period. A first conversion gives it at edge 3+28·h. Completion comes at edge 3+27·h for a normal conversion and 3+51·h for a first one.
- R7: In free-running mode (`mode`=1), a new conversion starts at the completion edge and `start_bit` stays high, so strobes repeat every 13 conversion-clock cycles.
- R8: `done_flag` stays high until a `flag_clr` pulse clears it.
- R9: A `start_set` during a conversion has no effect: the conversion's timing is unchanged and no extra conversion follows.
- R10: Dropping `en` aborts a running conversion with no completion, clears `start_bit`, and re-arms the long first conversion.
- R11: `result` holds its value while `data_in` changes, until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| start_set | input | 1 | Software start request pulse |
| flag_clr | input | 1 | Clears the completion flag |
| mode | input | 2 | 0 single, 1 free-running, 2 triggered, 3 as single |
| psel | input | 3 | Divider select |
| trig_in | input | 1 | Asynchronous trigger source |
| data_in | input | 10 | Converted value from the analog model |
| sample_strobe | output | 1 | Sample-and-hold pulse |
| result | output | 10 | Latched conversion result |
| done_flag | output | 1 | Completion flag |
| start_bit | output | 1 | Start status |

## Verification
The assertions watch a set of local rules on every cycle. The divider is idle while disabled and restarts on a trigger. A synchronised trigger edge always follows a high input two cycles earlier. A strobe only ever comes out of a running conversion. Single completions drop the start status, free-running completions keep the converter busy, and a low enable leaves nothing running. The absolute latencies can only be shown by the bench's scenarios: trigger to strobe, trigger to completion, the 25-cycle first conversion, every divider setting, the free-running period, flag persistence, the ignored start request, and abort with its re-arm.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_AUTO   = 2'd2,
    MODE_RSVD   = 2'd3
  } adc_mode_e;

  localparam int NORM_HALVES  = 26;
  localparam int FIRST_HALVES = 50;
  localparam int NORM_SAMPLE  = 3;
  localparam int FIRST_SAMPLE = 27;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [SEL_W-1:0] psel,
  output logic             tick,
  output logic             rise
);
  localparam int CNT_W = (MAX_SEL > 0) ? MAX_SEL : 1;
  localparam logic [SEL_W-1:0] MAX_SEL_V = SEL_W'(MAX_SEL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic [SEL_W-1:0] sel_eff;
  logic [CNT_W:0]   half;
  logic [CNT_W-1:0] half_m1;

  always_comb begin
    sel_eff = (psel > MAX_SEL_V) ? MAX_SEL_V : psel;
    half    = (CNT_W+1)'(1) << sel_eff;
    half_m1 = CNT_W'(half - 1'b1);
    tick    = en && !restart && (cnt_q >= half_m1);
    rise    = tick && !ph_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!en || restart) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0) && !ph_q);
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && restart) |=> (cnt_q == '0) && !ph_q);
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic trig_edge
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= trig_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign trig_edge = s2_q && !s3_q;

  a_r6_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge |-> $past(trig_in, 2));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  adc_mode_e        mode,
  input  logic             tick,
  input  logic             rise,
  input  logic             trig_go,
  input  logic             start_set,
  input  logic             flag_clr,
  input  logic [RES_W-1:0] data_in,
  output logic             busy,
  output logic             start_bit,
  output logic             done_flag,
  output logic             sample_strobe,
  output logic [RES_W-1:0] result
);
  localparam int HCNT_W = $clog2(FIRST_HALVES + 1);
  localparam logic [HCNT_W-1:0] TOT_N  = HCNT_W'(NORM_HALVES);
  localparam logic [HCNT_W-1:0] TOT_F  = HCNT_W'(FIRST_HALVES);
  localparam logic [HCNT_W-1:0] SAMP_N = HCNT_W'(NORM_SAMPLE);
  localparam logic [HCNT_W-1:0] SAMP_F = HCNT_W'(FIRST_SAMPLE);

  logic [HCNT_W-1:0] hcnt_q, hcnt_d, hcnt_inc, total, samp;
  logic              busy_d, start_d, first_q, first_d, flag_d, strobe_d;
  logic [RES_W-1:0]  res_d;
  logic              done;

  always_comb begin
    hcnt_inc = hcnt_q + 1'b1;
    total    = first_q ? TOT_F : TOT_N;
    samp     = first_q ? SAMP_F : SAMP_N;
    done     = tick && busy && (hcnt_inc == total);
  end

  always_comb begin
    hcnt_d   = hcnt_q;
    busy_d   = busy;
    start_d  = start_bit;
    first_d  = first_q;
    flag_d   = done_flag;
    res_d    = result;
    strobe_d = tick && busy && (hcnt_inc == samp);
    if (flag_clr) flag_d = 1'b0;
    if (!en) begin
      hcnt_d   = '0;
      busy_d   = 1'b0;
      start_d  = 1'b0;
      first_d  = 1'b1;
      strobe_d = 1'b0;
    end else begin
      if (trig_go) begin
        start_d = 1'b1;
      end else if (start_set && !busy && mode != MODE_AUTO) begin
        start_d = 1'b1;
      end
      if (tick && busy) begin
        hcnt_d = hcnt_inc;
        if (done) begin
          res_d   = data_in;
          flag_d  = 1'b1;
          first_d = 1'b0;
          if (mode == MODE_FREE) begin
            hcnt_d = '0;
          end else begin
            busy_d  = 1'b0;
            start_d = 1'b0;
          end
        end
      end else if (rise && !busy && start_bit) begin
        busy_d = 1'b1;
        hcnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q        <= '0;
      busy          <= 1'b0;
      start_bit     <= 1'b0;
      first_q       <= 1'b1;
      done_flag     <= 1'b0;
      sample_strobe <= 1'b0;
      result        <= '0;
    end else begin
      hcnt_q        <= hcnt_d;
      busy          <= busy_d;
      start_bit     <= start_d;
      first_q       <= first_d;
      done_flag     <= flag_d;
      sample_strobe <= strobe_d;
      result        <= res_d;
    end
  end

  a_r4_strobe_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> $past(busy));
  a_r5_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode != MODE_FREE) |=> !start_bit && done_flag);
  a_r7_free_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == MODE_FREE) |=> busy && start_bit);
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy && !start_bit);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_set,
  input  logic             flag_clr,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] psel,
  input  logic             trig_in,
  input  logic [RES_W-1:0] data_in,
  output logic             sample_strobe,
  output logic [RES_W-1:0] result,
  output logic             done_flag,
  output logic             start_bit
);
  logic      rs1_q, rs2_q;
  logic      tick, rise, trig_edge, trig_go, busy;
  adc_mode_e mode_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign mode_e  = adc_mode_e'(mode);
  assign trig_go = trig_edge && en && (mode_e == MODE_AUTO) && !busy;

  adc_trig_sync u_sync (
    .clk       (clk),
    .rst_n     (rs2_q),
    .trig_in   (trig_in),
    .trig_edge (trig_edge)
  );

  adc_prescaler #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_presc (
    .clk     (clk),
    .rst_n   (rs2_q),
    .en      (en),
    .restart (trig_go),
    .psel    (psel),
    .tick    (tick),
    .rise    (rise)
  );

  adc_conv_seq #(.RES_W(RES_W)) u_seq (
    .clk           (clk),
    .rst_n         (rs2_q),
    .en            (en),
    .mode          (mode_e),
    .tick          (tick),
    .rise          (rise),
    .trig_go       (trig_go),
    .start_set     (start_set),
    .flag_clr      (flag_clr),
    .data_in       (data_in),
    .busy          (busy),
    .start_bit     (start_bit),
    .done_flag     (done_flag),
    .sample_strobe (sample_strobe),
    .result        (result)
  );
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 8;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n, en, start_set, flag_clr, trig_in;
  logic [1:0] mode;
  logic [2:0] psel;
  logic [9:0] data_in;
  logic       sample_strobe, done_flag, start_bit;
  logic [9:0] result;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // Row: {psel, first conversion, trigger->strobe edge, trigger->flag edge}
  localparam int ROWS [NROWS][4] = '{
    '{0, 1,   31,   54},
    '{0, 0,    7,   30},
    '{1, 0,   11,   57},
    '{2, 1,  115,  207},
    '{3, 0,   35,  219},
    '{5, 1,  899, 1635},
    '{6, 0,  259, 1731},
    '{7, 0,  259, 1731}
  };

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .en(en), .start_set(start_set), .flag_clr(flag_clr),
    .mode(mode), .psel(psel), .trig_in(trig_in), .data_in(data_in),
    .sample_strobe(sample_strobe), .result(result), .done_flag(done_flag),
    .start_bit(start_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
  endtask

  task automatic pulse_start();
    start_set = 1'b1; cyc(1); start_set = 1'b0;
  endtask

  // Raise trig_in and count edges to the strobe and to the flag.
  task automatic trig_measure(output int ns, output int nf);
    int n = 0;
    ns = -1; nf = -1;
    trig_in = 1'b1;
    for (int k = 0; k < 4000; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (sample_strobe && ns < 0) ns = n;
      if (done_flag) begin nf = n; break; end
    end
    trig_in = 1'b0;
  endtask

  task automatic wait_strobe(output int n);
    n = -1;
    for (int k = 1; k < 4000; k++) begin
      cyc(1);
      if (sample_strobe) begin n = k; break; end
    end
  endtask

  task automatic wait_flag(output int n, output bit sb_at_flag);
    n = -1; sb_at_flag = 1'b1;
    for (int k = 1; k < 4000; k++) begin
      cyc(1);
      if (done_flag) begin n = k; sb_at_flag = start_bit; break; end
    end
  endtask

  initial begin
    int ns, nf, n, n2;
    bit sb;
    rst_n = 1'b0; en = 1'b0; start_set = 1'b0; flag_clr = 1'b0; trig_in = 1'b0;
    mode = 2'd0; psel = 3'd0; data_in = '0;
    cyc(3);
    check(result == 0 && !done_flag && !start_bit && !sample_strobe, "reset", result, 0);
    rst_n = 1'b1;
    cyc(4);

    // Table walk: triggered latency across divider settings (R1 R3 R4 R5 R6)
    for (int r = 0; r < NROWS; r++) begin
      en = 1'b0; cyc(2); pulse_clr();
      mode = 2'd2; psel = 3'(ROWS[r][0]); en = 1'b1; cyc(3);
      if (ROWS[r][1] == 0) begin
        trig_measure(ns, nf);
        cyc(4); pulse_clr(); cyc(4);
      end
      data_in = 10'(37 * r + 5);
      trig_measure(ns, nf);
      check(ns == ROWS[r][2], "R4 R6 trigger to strobe", ns, ROWS[r][2]);
      check(nf == ROWS[r][3], "R1 R3 trigger to completion", nf, ROWS[r][3]);
      check(result == 10'(37 * r + 5), "R5 result latched", result, 37 * r + 5);
      cyc(3); pulse_clr();
    end

    // R2 start ignored while disabled
    en = 1'b0; mode = 2'd0; psel = 3'd0; cyc(2);
    pulse_start(); cyc(2);
    check(!start_bit, "R2 start while disabled", start_bit, 0);

    // Single mode, R9 start during conversion
    pulse_clr(); en = 1'b1; cyc(2); data_in = 10'h2A5;
    pulse_start();
    check(start_bit, "R2 start_bit set", start_bit, 1);
    wait_strobe(n);
    check(n > 0, "R2 conversion begins", n, 1);
    check(start_bit, "R5 start_bit high mid conversion", start_bit, 1);
    pulse_start();
    wait_flag(n, sb);
    check(n + 1 == 23, "R4 R9 strobe to flag", n + 1, 23);
    check(!sb, "R5 start_bit cleared with flag", sb, 0);
    check(result == 10'h2A5, "R5 single result", result, 10'h2A5);
    data_in = 10'h0F0;
    ns = 0;
    for (int k = 0; k < 150; k++) begin cyc(1); if (sample_strobe) ns++; end
    check(ns == 0, "R9 no extra conversion", ns, 0);
    check(result == 10'h2A5, "R11 result held", result, 10'h2A5);
    check(done_flag, "R8 flag persists", done_flag, 1);
    pulse_clr(); cyc(1);
    check(!done_flag, "R8 flag cleared", done_flag, 0);

    // R7 free-running with psel=1 (h=2), period 52 cycles
    en = 1'b0; cyc(2); mode = 2'd1; psel = 3'd1; en = 1'b1; cyc(2);
    pulse_start();
    wait_strobe(n);
    wait_strobe(n);
    check(n == 52, "R7 free period after first", n, 52);
    wait_strobe(n2);
    check(n2 == 52, "R7 free period normal", n2, 52);
    check(start_bit && done_flag, "R7 start_bit stays high", start_bit, 1);

    // R10 abort mid conversion, then re-armed first conversion
    en = 1'b0; cyc(2); pulse_clr(); mode = 2'd0; psel = 3'd0; en = 1'b1; cyc(2);
    pulse_start();
    wait_strobe(n);
    en = 1'b0;
    cyc(100);
    check(!done_flag, "R10 abort no completion", done_flag, 0);
    check(!start_bit, "R10 abort clears start", start_bit, 0);
    mode = 2'd2; en = 1'b1; cyc(3);
    trig_measure(ns, nf);
    check(ns == 31, "R10 first conversion re-armed", ns, 31);

    summary();
  end
endmodule